// File: doc/BRIEF.md
# Inter-Access Bus Turnaround Controller

This block sits beside an external-memory access sequencer. It decides when the next queued access may start so that the controller and a slow device never drive the shared data bus at the same time. It tracks the access in flight, including its chip-select and whether it is a read. It notes when that read released the bus, meaning the first of its chip-select or output-enable deassertions. It also notes when the access finished. From these it keeps two free-running elapsed-cycle counters.

Each chip-select has a turnaround count, which protects against contention after a read. Each chip-select also has a gap count, which spaces consecutive accesses. The gap has separate enables for a transition to the same chip-select and for a transition from a different one. The turnaround count of the access that just ended is applied only to certain classes of next access. The gap count of the requested chip-select is applied according to its enables. The two windows overlap: the next access waits for whichever ends later. A grant is issued in the same cycle as the request whenever no window holds it back. The block also drives the data-direction output and the bus-keeper enable. The bus switches back to output, and keeping starts, only once the turnaround has run out.

Top module: `bus_gap_ctrl`

## Requirements
- R1: After reset, `grant` is low while `req_valid` is low. `dir_out` is 1 (controller drives) and `keeper_en` is 1. A request made with no history is granted in the same cycle.
- R2: An access is open from the clock edge where `grant` is high until the edge where `acc_end` is high. While an access is open, `grant` stays low. When no window applies, `grant` equals `req_valid` in the same cycle.
- R3: During an open read, the release point is the first edge where either `cs_off` or `oe_off` is high; later pulses are ignored. If neither pulses, the release point is the `acc_end` edge. For a read ending on chip-select P with turnaround T = `cfg_turn[4P+3:4P]`, a held request is granted only after T edges have passed the release point.
- R4: A turnaround value of 0 on the ending chip-select adds no delay for any next access.
- R5: Turnaround applies when the next request is a write (`req_wr`=1) to any chip-select, including P. It also applies to a read to a chip-select other than P, and to any access to a chip-select N whose bit `cfg_muxed[N]` is 1. It does not apply to a read to P when `cfg_muxed[P]`=0.
- R6: The turnaround value comes from the ending access's chip-select. The gap value G = `cfg_gap[4N+3:4N]` comes from the requested chip-select N.
- R7: The gap is enabled by `cfg_gap_same_en[N]` when N equals P, and by `cfg_gap_diff_en[N]` otherwise. When enabled, a request is granted no earlier than G edges after the `acc_end` edge. When disabled, the gap adds no delay.
- R8: The two windows overlap. The wait after `acc_end` is the larger of G and the turnaround remaining, never their sum.
- R9: `dir_out` is 0 while a read is open and while the turnaround of the last read is running; otherwise it is 1. `keeper_en` is 1 only when no access is open and `dir_out` is 1.
- R10: After a write access, no turnaround applies to the next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_turn | input | NUM_CS*DLY_W | Turnaround count per chip-select, 4 bits each, CS0 in the low nibble |
| cfg_gap | input | NUM_CS*DLY_W | Gap count per chip-select, 4 bits each, CS0 in the low nibble |
| cfg_gap_same_en | input | NUM_CS | Per-CS enable of the gap when the previous access used the same CS |
| cfg_gap_diff_en | input | NUM_CS | Per-CS enable of the gap when the previous access used another CS |
| cfg_muxed | input | NUM_CS | Per-CS flag: device shares address and data lines |
| req_valid | input | 1 | Next access is waiting |
| req_cs | input | CS_W | Chip-select of the waiting access |
| req_wr | input | 1 | 1 = waiting access is a write, 0 = read |
| cs_off | input | 1 | Chip-select of the open access deasserts this cycle |
| oe_off | input | 1 | Output enable of the open access deasserts this cycle |
| acc_end | input | 1 | Open access completes this cycle |
| grant | output | 1 | Waiting access may start this cycle |
| dir_out | output | 1 | Data direction: 1 = controller drives, 0 = device drives |
| keeper_en | output | 1 | Bus keeper enable |

## Verification
The bench measures the wait between `acc_end` and `grant` for each kind of transition. It checks write after read on the same chip-select, where a design that tested only for a chip-select change would issue the write at once. It checks a same-chip-select read, where a design that always waited would lose cycles. It checks a multiplexed target, where a design that ignored the flag would grant early. One case has the chip-select deassert three cycles before the output enable; a design that timed from the later release would return a longer wait. Overlapping windows, where adding them would give a longer wait, and expired or zero turnarounds are also covered. A directed run follows the direction pin through a read and its turnaround, and it confirms that a write is granted in the same cycle the bus turns to output.

// File: rtl/bgc_pkg.sv
package bgc_pkg;

   // Status of the access currently (or most recently) on the bus.
   typedef struct packed {
      logic open;       // granted and not yet completed
      logic rd;         // access is a read
      logic released;   // read has let go of the bus (first CS/OE deassertion seen)
   } acc_state_t;

   // Selects which gap enable governs a transition.
   function automatic logic gap_enable(input logic same_cs,
                                       input logic en_same,
                                       input logic en_diff);
      return same_cs ? en_same : en_diff;
   endfunction

endpackage

// File: rtl/bgc_elapsed.sv
// Saturating count of edges since the last restart; resets to saturation
// so that an idle bus holds no window open.
module bgc_elapsed #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         restart,
   output logic [W-1:0] cnt
);

   localparam logic [W-1:0] SAT = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= SAT;
      end else if (restart) begin
         cnt <= '0;
      end else if (cnt != SAT) begin
         cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/bgc_gap_eval.sv
// Classifies the waiting access against the last one and reports which
// windows still hold it back.
module bgc_gap_eval
   import bgc_pkg::*;
#(
   parameter int NUM_CS = 8,
   parameter int DLY_W  = 4,
   parameter int CS_W   = 3
) (
   input  logic [NUM_CS*DLY_W-1:0] cfg_turn,
   input  logic [NUM_CS*DLY_W-1:0] cfg_gap,
   input  logic [NUM_CS-1:0]       cfg_gap_same_en,
   input  logic [NUM_CS-1:0]       cfg_gap_diff_en,
   input  logic [NUM_CS-1:0]       cfg_muxed,
   input  acc_state_t              last_st,
   input  logic [CS_W-1:0]         last_cs,
   input  logic [DLY_W-1:0]        since_rel,
   input  logic [DLY_W-1:0]        since_end,
   input  logic [CS_W-1:0]         req_cs,
   input  logic                    req_wr,
   output logic                    turn_active,
   output logic                    turn_hold,
   output logic                    gap_hold
);

   logic [DLY_W-1:0] turn_tab [NUM_CS];
   logic [DLY_W-1:0] gap_tab  [NUM_CS];

   for (genvar gi = 0; gi < NUM_CS; gi++) begin : g_unpack
      assign turn_tab[gi] = cfg_turn[gi*DLY_W +: DLY_W];
      assign gap_tab[gi]  = cfg_gap[gi*DLY_W +: DLY_W];
   end

   logic same_cs;
   logic turn_class;
   logic gap_on;

   always_comb begin
      // Turnaround belongs to the ending access and runs from its release.
      turn_active = last_st.rd && last_st.released &&
                    (since_rel < turn_tab[last_cs]);
      same_cs     = (req_cs == last_cs);
      // Only a same-CS read to a non-multiplexed device escapes the turnaround.
      turn_class  = req_wr || !same_cs || cfg_muxed[req_cs];
      turn_hold   = turn_active && turn_class;
      // Gap belongs to the following access and runs from completion.
      gap_on      = gap_enable(same_cs, cfg_gap_same_en[req_cs], cfg_gap_diff_en[req_cs]);
      gap_hold    = gap_on && (since_end < gap_tab[req_cs]);
   end

endmodule

// File: rtl/bgc_dir_seq.sv
// Data-direction and keeper sequencing: the bus turns to output only after
// the device has had its turnaround time.
module bgc_dir_seq
   import bgc_pkg::*;
(
   input  acc_state_t st,
   input  logic       turn_active,
   output logic       dir_out,
   output logic       keeper_en
);

   logic dev_owns_bus;

   always_comb begin
      dev_owns_bus = st.rd && (st.open || turn_active);
      dir_out      = !dev_owns_bus;
      keeper_en    = !st.open && !dev_owns_bus;
   end

endmodule

// File: rtl/bus_gap_ctrl.sv
module bus_gap_ctrl
   import bgc_pkg::*;
#(
   parameter int NUM_CS = 8,
   parameter int DLY_W  = 4,
   parameter int CS_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NUM_CS*DLY_W-1:0] cfg_turn,
   input  logic [NUM_CS*DLY_W-1:0] cfg_gap,
   input  logic [NUM_CS-1:0]       cfg_gap_same_en,
   input  logic [NUM_CS-1:0]       cfg_gap_diff_en,
   input  logic [NUM_CS-1:0]       cfg_muxed,
   input  logic                    req_valid,
   input  logic [CS_W-1:0]         req_cs,
   input  logic                    req_wr,
   input  logic                    cs_off,
   input  logic                    oe_off,
   input  logic                    acc_end,
   output logic                    grant,
   output logic                    dir_out,
   output logic                    keeper_en
);

   // Elaboration-time parameter checks.
   if (NUM_CS < 2 || (1 << CS_W) != NUM_CS) begin : g_bad_cs
      $error("bus_gap_ctrl: NUM_CS must be a power of two >= 2 matching CS_W");
   end
   if (DLY_W < 1 || DLY_W > 8) begin : g_bad_dly
      $error("bus_gap_ctrl: DLY_W must lie in 1..8");
   end

   acc_state_t      st_q;
   logic [CS_W-1:0] cs_q;
   logic            busy_q;
   logic            cur_rd_q;
   logic            rel_fire;
   logic            end_fire;
   logic [DLY_W-1:0] since_rel;
   logic [DLY_W-1:0] since_end;
   logic            turn_active;
   logic            turn_hold;
   logic            gap_hold;

   assign busy_q   = st_q.open;
   assign cur_rd_q = st_q.rd;

   // First bus release of an open read; completion stands in if none came.
   assign rel_fire = st_q.open && st_q.rd && !st_q.released &&
                     (cs_off || oe_off || acc_end);
   assign end_fire = st_q.open && acc_end;

   assign grant = req_valid && !st_q.open && !turn_hold && !gap_hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= '0;
         cs_q <= '0;
      end else if (grant) begin
         st_q.open     <= 1'b1;
         st_q.rd       <= !req_wr;
         st_q.released <= 1'b0;
         cs_q          <= req_cs;
      end else begin
         if (end_fire) st_q.open     <= 1'b0;
         if (rel_fire) st_q.released <= 1'b1;
      end
   end

   bgc_elapsed #(.W(DLY_W)) u_rel_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (rel_fire),
      .cnt     (since_rel)
   );

   bgc_elapsed #(.W(DLY_W)) u_end_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (end_fire),
      .cnt     (since_end)
   );

   bgc_gap_eval #(.NUM_CS(NUM_CS), .DLY_W(DLY_W), .CS_W(CS_W)) u_eval (
      .cfg_turn        (cfg_turn),
      .cfg_gap         (cfg_gap),
      .cfg_gap_same_en (cfg_gap_same_en),
      .cfg_gap_diff_en (cfg_gap_diff_en),
      .cfg_muxed       (cfg_muxed),
      .last_st         (st_q),
      .last_cs         (cs_q),
      .since_rel       (since_rel),
      .since_end       (since_end),
      .req_cs          (req_cs),
      .req_wr          (req_wr),
      .turn_active     (turn_active),
      .turn_hold       (turn_hold),
      .gap_hold        (gap_hold)
   );

   bgc_dir_seq u_dir (
      .st          (st_q),
      .turn_active (turn_active),
      .dir_out     (dir_out),
      .keeper_en   (keeper_en)
   );

endmodule

// File: rtl/bgc_chk.sv
module bgc_chk (
   input logic clk,
   input logic rst_n,
   input logic grant,
   input logic req_wr,
   input logic acc_end,
   input logic dir_out,
   input logic keeper_en,
   input logic busy_q,
   input logic cur_rd_q
);

   // R2: no new start while an access is open
   assert_no_grant_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> !grant);

   // R2: a completion edge never coincides with a new start
   assert_no_grant_at_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && acc_end) |-> !grant);

   // R9: device owns the bus during an open read
   assert_dir_in_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && cur_rd_q) |-> !dir_out);

   // R9: keeper only when controller owns the bus and it is idle
   assert_keeper_dir_R9: assert property (@(posedge clk) disable iff (!rst_n)
      keeper_en |-> (dir_out && !busy_q));

   // R5: a write is only started once the bus already points outward
   assert_write_dir_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (grant && req_wr) |-> dir_out);

endmodule

bind bus_gap_ctrl bgc_chk u_bgc_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .grant     (grant),
   .req_wr    (req_wr),
   .acc_end   (acc_end),
   .dir_out   (dir_out),
   .keeper_en (keeper_en),
   .busy_q    (busy_q),
   .cur_rd_q  (cur_rd_q)
);

// File: tb/bus_gap_ctrl_tb_top.sv
module bus_gap_ctrl_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NUM_CS = 8;
   localparam int DLY_W  = 4;
   localparam int CS_W   = 3;
   localparam int NVEC   = 12;

   // Vector: prev_cs[23:21] prev_rd[20] next_cs[19:17] next_wr[16]
   //         cs_off_at[15:12] oe_off_at[11:8] end_at[7:4] exp_wait[3:0]
   // (cycle offsets counted in edges after the grant edge)
   localparam logic [23:0] VEC [NVEC] = '{
      {3'd0, 1'b1, 3'd0, 1'b1, 4'd3, 4'd2, 4'd3, 4'd3},
      {3'd0, 1'b1, 3'd0, 1'b0, 4'd2, 4'd3, 4'd3, 4'd2},
      {3'd0, 1'b1, 3'd1, 1'b0, 4'd1, 4'd1, 4'd1, 4'd4},
      {3'd1, 1'b1, 3'd2, 1'b1, 4'd2, 4'd2, 4'd2, 4'd0},
      {3'd2, 1'b0, 3'd3, 1'b0, 4'd1, 4'd1, 4'd2, 4'd0},
      {3'd3, 1'b1, 3'd3, 1'b0, 4'd1, 4'd1, 4'd1, 4'd5},
      {3'd2, 1'b1, 3'd4, 1'b0, 4'd1, 4'd4, 4'd4, 4'd3},
      {3'd4, 1'b1, 3'd4, 1'b0, 4'd1, 4'd1, 4'd1, 4'd3},
      {3'd5, 1'b1, 3'd0, 1'b1, 4'd2, 4'd2, 4'd4, 4'd2},
      {3'd2, 1'b1, 3'd2, 1'b0, 4'd1, 4'd1, 4'd1, 4'd0},
      {3'd6, 1'b1, 3'd6, 1'b1, 4'd1, 4'd1, 4'd1, 4'd1},
      {3'd3, 1'b1, 3'd4, 1'b1, 4'd1, 4'd1, 4'd1, 4'd2}
   };
   localparam string VTAG [NVEC] = '{
      "R3 R5 R8 write after read same cs",
      "R5 R7 same-cs read skips turnaround",
      "R5 R8 read to other cs",
      "R4 zero turnaround",
      "R10 R7 after write, gap disabled",
      "R7 same-cs gap",
      "R3 R5 R6 earliest release, muxed target",
      "R5 muxed same cs",
      "R6 R8 turnaround already expired",
      "R5 same-cs read no wait",
      "R3 write after short turnaround",
      "R6 R8 overlap not sum"
   };

   logic                    clk;
   logic                    rst_n;
   logic [NUM_CS*DLY_W-1:0] cfg_turn;
   logic [NUM_CS*DLY_W-1:0] cfg_gap;
   logic [NUM_CS-1:0]       cfg_gap_same_en;
   logic [NUM_CS-1:0]       cfg_gap_diff_en;
   logic [NUM_CS-1:0]       cfg_muxed;
   logic                    req_valid;
   logic [CS_W-1:0]         req_cs;
   logic                    req_wr;
   logic                    cs_off;
   logic                    oe_off;
   logic                    acc_end;
   logic                    grant;
   logic                    dir_out;
   logic                    keeper_en;

   int n_chk = 0;
   int n_bad = 0;

   bus_gap_ctrl #(.NUM_CS(NUM_CS), .DLY_W(DLY_W), .CS_W(CS_W)) dut_i (
      .clk             (clk),
      .rst_n           (rst_n),
      .cfg_turn        (cfg_turn),
      .cfg_gap         (cfg_gap),
      .cfg_gap_same_en (cfg_gap_same_en),
      .cfg_gap_diff_en (cfg_gap_diff_en),
      .cfg_muxed       (cfg_muxed),
      .req_valid       (req_valid),
      .req_cs          (req_cs),
      .req_wr          (req_wr),
      .cs_off          (cs_off),
      .oe_off          (oe_off),
      .acc_end         (acc_end),
      .grant           (grant),
      .dir_out         (dir_out),
      .keeper_en       (keeper_en)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic close_access();
      cs_off = 1'b1; oe_off = 1'b1; acc_end = 1'b1;
      step();
      cs_off = 1'b0; oe_off = 1'b0; acc_end = 1'b0;
   endtask

   task automatic run_vec(input logic [23:0] v, input string tag);
      int w;
      repeat (20) step();
      req_valid = 1'b1; req_cs = v[23:21]; req_wr = !v[20];
      #1;
      check({"R2 idle grant: ", tag}, int'(grant), 1);
      step();
      req_valid = 1'b0;
      for (int j = 1; j <= int'(v[7:4]); j++) begin
         cs_off  = (j == int'(v[15:12]));
         oe_off  = (j == int'(v[11:8]));
         acc_end = (j == int'(v[7:4]));
         step();
         cs_off = 1'b0; oe_off = 1'b0; acc_end = 1'b0;
      end
      req_valid = 1'b1; req_cs = v[19:17]; req_wr = v[16];
      w = 0;
      #1;
      while (!grant && w < 40) begin
         step();
         #1;
         w++;
      end
      check({"wait: ", tag}, w, int'(v[3:0]));
      step();
      req_valid = 1'b0;
      close_access();
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog R2 actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      int w;
      rst_n = 1'b0;
      // turnaround per CS (cs7..cs0): 1 1 1 3 2 6 0 4
      cfg_turn        = 32'h1113_2604;
      // gap per CS (cs7..cs0): 0 0 0 1 5 0 3 2
      cfg_gap         = 32'h0001_5032;
      cfg_gap_same_en = 8'b0000_1001;
      cfg_gap_diff_en = 8'b0001_0011;
      cfg_muxed       = 8'b0001_0000;
      req_valid = 1'b0; req_cs = '0; req_wr = 1'b0;
      cs_off = 1'b0; oe_off = 1'b0; acc_end = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R1 reset grant", int'(grant), 0);
      check("R1 reset dir_out", int'(dir_out), 1);
      check("R1 reset keeper_en", int'(keeper_en), 1);

      // Directed: read on CS2 (turnaround 6) then write to CS3 (gap disabled)
      @(negedge clk);
      req_valid = 1'b1; req_cs = 3'd2; req_wr = 1'b0;
      #1;
      check("R1 first request granted at once", int'(grant), 1);
      step();
      req_cs = 3'd3; req_wr = 1'b1;
      #1;
      check("R2 no grant while open", int'(grant), 0);
      check("R9 dir in during read", int'(dir_out), 0);
      check("R9 keeper off during read", int'(keeper_en), 0);
      cs_off = 1'b1; acc_end = 1'b1;
      step();
      cs_off = 1'b0; acc_end = 1'b0;
      #1;
      check("R9 dir stays in during turnaround", int'(dir_out), 0);
      w = 0;
      while (!dir_out && w < 40) begin
         step();
         #1;
         w++;
      end
      check("R9 dir turns out after turnaround", w, 6);
      check("R5 write granted as bus turns", int'(grant), 1);
      step();
      req_valid = 1'b0;
      #1;
      check("R9 dir out during write", int'(dir_out), 1);
      check("R9 keeper off while write open", int'(keeper_en), 0);
      close_access();

      for (int i = 0; i < NVEC; i++) run_vec(VEC[i], VTAG[i]);

      // Directed: OE released first, later CS pulse ignored (R3)
      repeat (20) step();
      req_valid = 1'b1; req_cs = 3'd0; req_wr = 1'b0;
      step();
      req_valid = 1'b0;
      oe_off = 1'b1; step(); oe_off = 1'b0;
      step(); step();
      cs_off = 1'b1; acc_end = 1'b1; step(); cs_off = 1'b0; acc_end = 1'b0;
      req_valid = 1'b1; req_cs = 3'd6; req_wr = 1'b1;
      w = 0;
      #1;
      while (!grant && w < 40) begin
         step();
         #1;
         w++;
      end
      check("R3 release from first of OE/CS", w, 1);
      step();
      req_valid = 1'b0;
      close_access();
      repeat (20) step();
      #1;
      check("R10 idle after write keeper on", int'(keeper_en), 1);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule